// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block drives the digital side of a successive-approximation converter. A start request clears the result register and raises a busy flag. The block then settles one result bit per enabled clock cycle, beginning with the most significant bit. In each step it places a trial code on a port that feeds an external DAC. A one-bit comparator answer decides whether the trial bit is kept or dropped. The analog parts (DAC, comparator, reference, input scaling) live outside this block.

The result is available in parallel. It is also streamed serially, non-return-to-zero and MSB first, while the conversion is running, together with a bit clock that pulses once for each decided bit. The output coding is complementary. A mode input chooses between plain complement and complement with the sign bit restored, which gives the two's-complement flavour. A short-cycle input stops the conversion at reduced resolution. A step-enable input (for an external timing source) and an inhibit input gate the progress. A free-run input chains conversions back to back without any command.

Top module: `sar_sequencer`

## Requirements
- R1: While reset is high and after it is released, `busy`, `serialOut` and `bitClk` are 0 and the internal result is all zeros (so `dataOut` shows 12'hFFF in mode 0).
- R2: A conversion starts only on a falling edge of `convCmd` seen while idle. `busy` is 1 from the first clock edge at which `convCmd` is sampled low after being sampled high. Holding `convCmd` high never starts a conversion.
- R3: At start the result is cleared. The first trial code on `dacCode` is 12'h800, and each trial code equals the bits kept so far with the bit under test set to 1, working from bit 11 downward.
- R4: A trial bit is kept when `cmpIn` is 1 (input at or above the trial level) and cleared otherwise. At full resolution the result therefore equals the input code.
- R5: With `shortCycle` = 0 at start, `busy` stays high for exactly 12 enabled cycles. With `shortCycle` = 1 it stays high for exactly 10, and bits 1:0 stay undecided (raw 0).
- R6: After each decision, `bitClk` is 1 for one cycle and `serialOut` carries the coded value of the bit just decided. Bits arrive MSB first.
- R7: No bit is decided and the conversion does not advance in a cycle where `stepEn` is 0 or `clkInhibit` is 1.
- R8: `codeMode` 0, 1 and 3 output the bitwise complement of the raw result. `codeMode` 2 outputs the complement with bit 11 not inverted. The serial bits use the same coding.
- R9: A falling edge on `convCmd` while busy is ignored: the running conversion completes unchanged and no new conversion follows it.
- R10: With `freeRun` = 1, the block stays idle for exactly one cycle after a conversion ends and then starts the next one without any command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| convCmd | input | 1 | Convert request; acts on its falling edge |
| freeRun | input | 1 | Chain conversions automatically |
| shortCycle | input | 1 | Stop at reduced resolution (sampled at start) |
| stepEn | input | 1 | Conversion step enable (external timing source) |
| clkInhibit | input | 1 | Suspends conversion stepping while high |
| codeMode | input | 2 | Output coding select |
| cmpIn | input | 1 | Comparator: 1 when input is at or above trial level |
| dacCode | output | 12 | Trial code for the external DAC (true binary) |
| dataOut | output | 12 | Coded parallel result |
| busy | output | 1 | Conversion in progress |
| serialOut | output | 1 | NRZ serial result, MSB first |
| bitClk | output | 1 | One pulse per decided bit |

## Verification
Every cycle, the assertions check several properties. A start always points at the MSB, and the bit index never drops below the stop point. A stalled step keeps the state frozen and keeps busy high. The register clears on a start. A decided bit takes exactly the comparator value. The serial bit agrees with the same bit of the parallel output. Only the bench's scenarios can show the following: the full-resolution result matching every input code, the exact conversion length for each resolution, MSB-first ordering of the captured stream, the coding modes, the rejection of a command during busy, and the one-cycle gap of free-running mode.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    CODE_CMPL_STRAIGHT = 2'd0,
    CODE_CMPL_OFFSET   = 2'd1,
    CODE_CMPL_TWOS     = 2'd2,
    CODE_CMPL_SPARE    = 2'd3
  } codeSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clearRes;  // wipe the result register (start of conversion)
    logic decide;    // commit the comparator answer into the bit under test
    logic trialOn;   // present the trial bit on the DAC port
  } seqStrobe_t;

  // Whether a result bit is inverted on the way out.
  function automatic logic invertOf(input logic [1:0] mode, input logic isMsb);
    return !((codeSel_e'(mode) == CODE_CMPL_TWOS) && isMsb);
  endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int FULL_BITS  = 12,
  parameter int SHORT_BITS = 10,
  parameter int IDX_W      = $clog2(FULL_BITS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      convCmd,
  input  logic                      freeRun,
  input  logic                      shortCycle,
  input  logic                      stepEn,
  input  logic                      clkInhibit,
  output logic                      busy,
  output logic [IDX_W-1:0]          bitIdx,
  output sar_seq_pkg::seqStrobe_t   strobe
);
  import sar_seq_pkg::*;

  localparam logic [IDX_W-1:0] MSB_IDX    = IDX_W'(FULL_BITS - 1);
  localparam logic [IDX_W-1:0] SHORT_STOP = IDX_W'(FULL_BITS - SHORT_BITS);

  logic             cmdPrev;
  logic             busyQ;
  logic             shortQ;
  logic [IDX_W-1:0] idxQ;
  logic             stepOk;
  logic             cmdFall;
  logic             startNow;
  logic [IDX_W-1:0] lastIdx;
  logic             atLast;

  always_comb begin
    stepOk   = stepEn && !clkInhibit;
    cmdFall  = cmdPrev && !convCmd;
    startNow = !busyQ && (cmdFall || freeRun);
    lastIdx  = shortQ ? SHORT_STOP : '0;
    atLast   = (idxQ == lastIdx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdPrev <= 1'b0;
      busyQ   <= 1'b0;
      shortQ  <= 1'b0;
      idxQ    <= MSB_IDX;
    end else begin
      cmdPrev <= convCmd;
      if (startNow) begin
        busyQ  <= 1'b1;
        shortQ <= shortCycle;
        idxQ   <= MSB_IDX;
      end else if (busyQ && stepOk) begin
        if (atLast) busyQ <= 1'b0;
        else        idxQ  <= idxQ - 1'b1;
      end
    end
  end

  always_comb begin
    strobe.clearRes = startNow;
    strobe.decide   = busyQ && stepOk;
    strobe.trialOn  = busyQ;
  end

  assign busy   = busyQ;
  assign bitIdx = idxQ;

  // R3: every conversion begins at the most significant bit
  p_msb_first_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busyQ) |-> (idxQ == MSB_IDX));

  // R5: the index never passes the selected stop point
  p_window_r5: assert property (@(posedge clk) disable iff (rst)
    busyQ |-> (idxQ >= lastIdx));

  // R7: a stalled step freezes progress
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busyQ && !stepOk) |=> (busyQ && $stable(idxQ)));

  // R9: only the final decision ends busy; commands cannot end it
  p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (busyQ && !(stepOk && atLast)) |=> busyQ);

endmodule

// File: rtl/sar_seq_dpath.sv
module sar_seq_dpath #(
  parameter int FULL_BITS = 12,
  parameter int IDX_W     = $clog2(FULL_BITS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  sar_seq_pkg::seqStrobe_t   strobe,
  input  logic [IDX_W-1:0]          bitIdx,
  input  logic                      cmpIn,
  input  logic [1:0]                codeMode,
  output logic [FULL_BITS-1:0]      dacCode,
  output logic [FULL_BITS-1:0]      dataOut,
  output logic                      serialOut,
  output logic                      bitClk
);
  import sar_seq_pkg::*;

  localparam logic [IDX_W-1:0]     MSB_IDX = IDX_W'(FULL_BITS - 1);
  localparam logic [FULL_BITS-1:0] ONE     = FULL_BITS'(1);

  logic [FULL_BITS-1:0] rawRes;
  logic [FULL_BITS-1:0] bitSel;
  logic                 serialNext;

  always_comb begin
    bitSel     = ONE << bitIdx;
    dacCode    = rawRes | (strobe.trialOn ? bitSel : '0);
    serialNext = cmpIn ^ invertOf(codeMode, bitIdx == MSB_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rawRes    <= '0;
      serialOut <= 1'b0;
      bitClk    <= 1'b0;
    end else begin
      bitClk <= strobe.decide;
      if (strobe.clearRes)    rawRes         <= '0;
      else if (strobe.decide) rawRes[bitIdx] <= cmpIn;
      if (strobe.decide) serialOut <= serialNext;
    end
  end

  for (genvar g = 0; g < FULL_BITS; g++) begin : g_code
    assign dataOut[g] = rawRes[g] ^ invertOf(codeMode, g == FULL_BITS - 1);
  end

  // R3: a start leaves no stale bits behind
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.clearRes |=> (rawRes == '0));

  // R4: the bit under test follows the comparator
  p_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.decide && cmpIn) |=> rawRes[$past(bitIdx)]);
  p_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.decide && !cmpIn) |=> !rawRes[$past(bitIdx)]);

  // R6: the serial bit matches the same bit of the parallel output
  p_serial_r6: assert property (@(posedge clk) disable iff (rst)
    bitClk |-> (serialOut == dataOut[$past(bitIdx)]));

  // R7: without a decide or clear the result is untouched
  p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!strobe.decide && !strobe.clearRes) |=> $stable(rawRes));

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int FULL_BITS  = 12,
  parameter int SHORT_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 convCmd,
  input  logic                 freeRun,
  input  logic                 shortCycle,
  input  logic                 stepEn,
  input  logic                 clkInhibit,
  input  logic [1:0]           codeMode,
  input  logic                 cmpIn,
  output logic [FULL_BITS-1:0] dacCode,
  output logic [FULL_BITS-1:0] dataOut,
  output logic                 busy,
  output logic                 serialOut,
  output logic                 bitClk
);
  import sar_seq_pkg::*;

  localparam int IDX_W = $clog2(FULL_BITS);

  seqStrobe_t       strobe;
  logic [IDX_W-1:0] bitIdx;

  sar_seq_ctrl #(
    .FULL_BITS (FULL_BITS),
    .SHORT_BITS(SHORT_BITS),
    .IDX_W     (IDX_W)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .convCmd   (convCmd),
    .freeRun   (freeRun),
    .shortCycle(shortCycle),
    .stepEn    (stepEn),
    .clkInhibit(clkInhibit),
    .busy      (busy),
    .bitIdx    (bitIdx),
    .strobe    (strobe)
  );

  sar_seq_dpath #(
    .FULL_BITS(FULL_BITS),
    .IDX_W    (IDX_W)
  ) i_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .bitIdx   (bitIdx),
    .cmpIn    (cmpIn),
    .codeMode (codeMode),
    .dacCode  (dacCode),
    .dataOut  (dataOut),
    .serialOut(serialOut),
    .bitClk   (bitClk)
  );

  // R1: the serial pair stays quiet while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !bitClk && !serialOut));

endmodule

// File: tb/test_sar_sequencer.sv
module test_sar_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, convCmd, freeRun, shortCycle, stepEn, clkInhibit, cmpIn;
  logic [1:0]  codeMode;
  logic [11:0] dacCode, dataOut, vinModel;
  logic        busy, serialOut, bitClk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural comparator: input at or above trial level
  assign cmpIn = (dacCode <= vinModel);

  sar_sequencer i_sar_sequencer (
    .clk(clk), .rst(rst), .convCmd(convCmd), .freeRun(freeRun),
    .shortCycle(shortCycle), .stepEn(stepEn), .clkInhibit(clkInhibit),
    .codeMode(codeMode), .cmpIn(cmpIn), .dacCode(dacCode), .dataOut(dataOut),
    .busy(busy), .serialOut(serialOut), .bitClk(bitClk)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [11:0] coded(input logic [11:0] raw, input logic [1:0] md);
    return (md == 2'd2) ? (raw ^ 12'h7FF) : ~raw;
  endfunction

  task automatic waitIdle();
    for (int n = 0; n < 200 && busy; n++) @(negedge clk);
  endtask

  task automatic doConv(input logic [11:0] v, input bit sc, input logic [1:0] md,
                        input bit inh, input bit poke, input string tag);
    logic [11:0] expOut, ser;
    int nb, got, busyCyc;
    vinModel = v; shortCycle = sc; codeMode = md;
    @(negedge clk) convCmd = 1'b1;
    @(negedge clk) convCmd = 1'b0;
    @(negedge clk);
    check(busy === 1'b1, "R2 busy after release", 32'(busy), 1);
    check(dacCode === 12'h800, "R3 first trial", 32'(dacCode), 32'h800);
    check(dataOut === coded(12'h000, md), "R3 cleared result", 32'(dataOut),
          32'(coded(12'h000, md)));
    nb = sc ? 10 : 12; ser = '0; got = 0; busyCyc = 0;
    for (int k = 0; k < 200; k++) begin
      if (bitClk) begin ser = {ser[10:0], serialOut}; got++; end
      if (!busy) break;
      busyCyc++;
      clkInhibit = inh && (k % 3 == 1);
      convCmd    = poke && (k == 2);
      @(negedge clk);
    end
    clkInhibit = 1'b0; convCmd = 1'b0;
    expOut = coded(sc ? (v & 12'hFFC) : v, md);
    check(dataOut === expOut, tag, 32'(dataOut), 32'(expOut));
    check(got == nb, "R6 bit pulse count", got, nb);
    check(ser == (expOut >> (12 - nb)), "R6 serial MSB first", 32'(ser),
          32'(expOut >> (12 - nb)));
    if (inh) check(busyCyc > nb, "R7 inhibit stretches", busyCyc, nb + 1);
    else     check(busyCyc == nb, "R5 conversion length", busyCyc, nb);
    if (!freeRun) begin
      @(negedge clk);
      check(busy === 1'b0, poke ? "R9 no restart" : "R2 stays idle", 32'(busy), 0);
    end
  endtask

  initial begin
    rst = 1'b1; convCmd = 1'b0; freeRun = 1'b0; shortCycle = 1'b0;
    stepEn = 1'b1; clkInhibit = 1'b0; codeMode = 2'd0; vinModel = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && bitClk === 1'b0 && serialOut === 1'b0, "R1 reset outputs",
          {busy, bitClk, serialOut}, 0);
    check(dataOut === 12'hFFF, "R1 reset result", 32'(dataOut), 32'hFFF);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0, "R1 idle after reset", 32'(busy), 0);

    // R2: held command never starts
    convCmd = 1'b1;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      check(busy === 1'b0, "R2 held high", 32'(busy), 0);
    end
    convCmd = 1'b0;
    @(negedge clk);
    check(busy === 1'b1, "R2 start on release", 32'(busy), 1);
    waitIdle();

    // R4: every input code at full resolution
    for (int v = 0; v < 4096; v++) doConv(12'(v), 1'b0, 2'd0, 1'b0, 1'b0, "R4 full result");

    // R5: reduced resolution
    for (int v = 0; v < 4096; v += 7) doConv(12'(v), 1'b1, 2'd0, 1'b0, 1'b0, "R5 short result");

    // R8: coding modes at corner codes
    for (int md = 0; md < 4; md++) begin
      doConv(12'h000, 1'b0, 2'(md), 1'b0, 1'b0, "R8 mode code");
      doConv(12'h7FF, 1'b0, 2'(md), 1'b0, 1'b0, "R8 mode code");
      doConv(12'h800, 1'b0, 2'(md), 1'b0, 1'b0, "R8 mode code");
      doConv(12'hFFF, 1'b1, 2'(md), 1'b0, 1'b0, "R8 mode code");
      doConv(12'hA5C, 1'b1, 2'(md), 1'b0, 1'b0, "R8 mode code");
    end

    // R7: inhibit pattern
    for (int v = 5; v < 4096; v += 511) doConv(12'(v), 1'b0, 2'd0, 1'b1, 1'b0, "R7 inhibited result");

    // R7: step enable low freezes progress
    vinModel = 12'h3C7; shortCycle = 1'b0; codeMode = 2'd0;
    @(negedge clk) convCmd = 1'b1;
    @(negedge clk) begin convCmd = 1'b0; stepEn = 1'b0; end
    repeat (5) @(negedge clk);
    check(busy === 1'b1 && dacCode === 12'h800, "R7 stepEn stall",
          32'(dacCode), 32'h800);
    check(bitClk === 1'b0, "R7 no decision", 32'(bitClk), 0);
    stepEn = 1'b1;
    waitIdle();
    check(dataOut === ~12'h3C7, "R7 result after stall", 32'(dataOut), 32'(~12'h3C7));

    // R9: command during busy ignored
    doConv(12'h9B1, 1'b0, 2'd0, 1'b0, 1'b1, "R9 result unchanged");
    doConv(12'h046, 1'b1, 2'd2, 1'b0, 1'b1, "R9 result unchanged");

    // R10: free-running
    @(negedge clk);
    vinModel = 12'h5A3; codeMode = 2'd0; shortCycle = 1'b0; freeRun = 1'b1;
    for (int n = 0; n < 5 && !busy; n++) @(negedge clk);
    check(busy === 1'b1, "R10 self start", 32'(busy), 1);
    waitIdle();
    check(dataOut === ~12'h5A3, "R10 free-run result", 32'(dataOut), 32'(~12'h5A3));
    @(negedge clk);
    check(busy === 1'b1 && dacCode === 12'h800, "R10 restart after one idle cycle",
          32'(dacCode), 32'h800);
    freeRun = 1'b0;
    waitIdle();
    @(negedge clk);
    check(busy === 1'b0, "R10 stops when cleared", 32'(busy), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule